// File: doc/BRIEF.md
# Registered/Buffered Command Stage

This block sits between a memory controller and an SDRAM array and re-drives every command, address and data-mask line toward the array. The lines it carries are the active-low chip selects, the active-low RAS, CAS and WE strobes, the clock enable, the bank select, the row/column address and the per-byte data masks.

A static mode input chooses between two behaviours. In registered mode every line is captured on a rising clock edge and driven to the array from the next edge onward. It then holds steady for the whole cycle, whatever the controller does in between. In buffered mode every line passes straight through in the same cycle.

Because registered mode adds one clock to everything the array sees, the block reports an effective CAS latency for the read-capture logic. This is the device latency plus one in registered mode, and the device latency unchanged in buffered mode. The block also presents a decoded view of the command the array will act on, as the array's own decoder would see it.

Top module: `cmd_redrive_stage`

## Requirements
- R1: With `reg_mode` high, each of `arr_cs_n`, `arr_ras_n`, `arr_cas_n`, `arr_we_n`, `arr_cke`, `arr_bank`, `arr_addr` and `arr_dqm` equals the value its controller-side input had at the preceding rising edge of `clk` (reset not asserted at that edge).
- R2: With `reg_mode` high, the array-side outputs do not change between rising edges even when the controller-side inputs change.
- R3: With `reg_mode` low, every array-side output equals its controller-side input in the same cycle, with no clock edge in between.
- R4: With `reg_mode` high, a rising edge with `rst_n` low sets all chip selects high, sets RAS/CAS/WE high (no-operation), drives clock enable low, clears bank and address to zero and sets every data-mask bit high.
- R5: With `reg_mode` low, `rst_n` has no effect: the outputs still follow the inputs while reset is held.
- R6: `eff_cl` equals `dev_cl + 1` with `reg_mode` high and equals `dev_cl` with `reg_mode` low, for every `dev_cl` value, with no wraparound (`eff_cl` is one bit wider).
- R7: `arr_cmd` is `{arr_ras_n, arr_cas_n, arr_we_n}` when at least one `arr_cs_n` bit is low, and is 3'b111 (no-operation) when all chip selects are high, regardless of the strobes.
- R8: Each data-mask bit travels independently with the same latency as the command lines: one clock in registered mode and zero in buffered mode, so a mask stays aligned with the command issued alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_mode | input | 1 | Static mode: 1 registered, 0 buffered |
| dev_cl | input | CL_W | Device CAS latency in clocks |
| ctl_cs_n | input | NUM_CS | Controller chip selects, active low |
| ctl_ras_n | input | 1 | Controller RAS strobe, active low |
| ctl_cas_n | input | 1 | Controller CAS strobe, active low |
| ctl_we_n | input | 1 | Controller WE strobe, active low |
| ctl_cke | input | 1 | Controller clock enable |
| ctl_bank | input | BANK_W | Controller bank select |
| ctl_addr | input | ADDR_W | Controller row/column address |
| ctl_dqm | input | MASK_W | Controller per-byte data masks |
| arr_cs_n | output | NUM_CS | Chip selects to the array |
| arr_ras_n | output | 1 | RAS to the array |
| arr_cas_n | output | 1 | CAS to the array |
| arr_we_n | output | 1 | WE to the array |
| arr_cke | output | 1 | Clock enable to the array |
| arr_bank | output | BANK_W | Bank select to the array |
| arr_addr | output | ADDR_W | Address to the array |
| arr_dqm | output | MASK_W | Data masks to the array |
| arr_cmd | output | 3 | Decoded command seen by the array |
| eff_cl | output | CL_W+1 | Effective CAS latency for read capture |

## Verification
In registered mode a value driven at a falling edge is due at the array outputs right after the next rising edge. The bench therefore checks it twice: a few nanoseconds after that edge, once the inputs have already been changed to unrelated values, and again at the following falling edge, before the next value is driven. In buffered mode the outputs are due in the same cycle, so they are checked one nanosecond after the inputs change, with no clock edge between stimulus and check. The reset values, the decoded command and the effective latency are checked at those same sample points. The expected values are computed from the stimulus alone.

// File: rtl/cmdstage_pkg.sv
// Shared constants and helpers for the command re-drive stage.
// Assumes the conventional active-low strobe encoding where all-high is a no-operation.
package cmdstage_pkg;

    localparam logic [2:0] CMD_NOP = 3'b111;

    // Forms the command code seen by an array whose decoder honours the chip selects.
    function automatic logic [2:0] cmd_code(input logic any_sel, input logic ras_n,
                                            input logic cas_n, input logic we_n);
        return any_sel ? {ras_n, cas_n, we_n} : CMD_NOP;
    endfunction

endpackage

// File: rtl/stage_reg.sv
// One pipeline register lane group with a synchronous active-low reset to a given value.
// Assumes RST_VAL is a constant of width W.
module stage_reg #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the inputs on every rising edge, or load the safe value under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/stage_sel.sv
// Chooses, lane by lane, between the combinational path and the registered path.
// Assumes sel is static during operation.
module stage_sel #(
    parameter int W = 8
) (
    input  logic         sel_reg,
    input  logic [W-1:0] d_thru,
    input  logic [W-1:0] d_reg,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        // Each lane takes the registered copy in registered mode, the live input otherwise.
        assign q[i] = sel_reg ? d_reg[i] : d_thru[i];
    end
endmodule

// File: rtl/cl_calc.sv
// Computes the CAS latency the read-capture logic must use, one bit wider than the device value.
// Assumes the mode adds exactly one clock of pipeline.
module cl_calc #(
    parameter int CL_W = 3
) (
    input  logic          reg_mode,
    input  logic [CL_W-1:0] dev_cl,
    output logic [CL_W:0]   eff_cl
);
    // Widen first so the addition cannot wrap.
    always_comb begin
        eff_cl = {1'b0, dev_cl} + {{CL_W{1'b0}}, reg_mode};
    end
endmodule

// File: rtl/cmd_redrive_stage.sv
// Top of the command re-drive stage: one-clock pipeline or pass-through for every
// control, address and mask line, plus decoded command and effective CAS latency.
// Assumes reg_mode is tied static; changing it is only meaningful around a reset.
module cmd_redrive_stage
    import cmdstage_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int MASK_W = 8,
    parameter int CL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_mode,
    input  logic [CL_W-1:0]   dev_cl,
    input  logic [NUM_CS-1:0] ctl_cs_n,
    input  logic              ctl_ras_n,
    input  logic              ctl_cas_n,
    input  logic              ctl_we_n,
    input  logic              ctl_cke,
    input  logic [BANK_W-1:0] ctl_bank,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [MASK_W-1:0] ctl_dqm,
    output logic [NUM_CS-1:0] arr_cs_n,
    output logic              arr_ras_n,
    output logic              arr_cas_n,
    output logic              arr_we_n,
    output logic              arr_cke,
    output logic [BANK_W-1:0] arr_bank,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [MASK_W-1:0] arr_dqm,
    output logic [2:0]        arr_cmd,
    output logic [CL_W:0]     eff_cl
);
    localparam int CTL_W = NUM_CS + 4;
    localparam int ADR_W = BANK_W + ADDR_W;

    localparam logic [CTL_W-1:0]  CTL_RST = {{NUM_CS{1'b1}}, CMD_NOP, 1'b0};
    localparam logic [ADR_W-1:0]  ADR_RST = '0;
    localparam logic [MASK_W-1:0] MSK_RST = '1;

    logic [CTL_W-1:0]  ctl_in, ctl_q, ctl_out;
    logic [ADR_W-1:0]  adr_in, adr_q, adr_out;
    logic [MASK_W-1:0] msk_q;

    assign ctl_in = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_cke};
    assign adr_in = {ctl_bank, ctl_addr};

    // Command strobes and clock enable: resets to deselect plus no-operation.
    stage_reg #(.W(CTL_W), .RST_VAL(CTL_RST)) u_ctl_reg (
        .clk(clk), .rst_n(rst_n), .d(ctl_in), .q(ctl_q));

    // Bank and address lanes.
    stage_reg #(.W(ADR_W), .RST_VAL(ADR_RST)) u_adr_reg (
        .clk(clk), .rst_n(rst_n), .d(adr_in), .q(adr_q));

    // Data masks, kept on the same pipeline depth as the commands.
    stage_reg #(.W(MASK_W), .RST_VAL(MSK_RST)) u_msk_reg (
        .clk(clk), .rst_n(rst_n), .d(ctl_dqm), .q(msk_q));

    stage_sel #(.W(CTL_W)) u_ctl_sel (
        .sel_reg(reg_mode), .d_thru(ctl_in), .d_reg(ctl_q), .q(ctl_out));

    stage_sel #(.W(ADR_W)) u_adr_sel (
        .sel_reg(reg_mode), .d_thru(adr_in), .d_reg(adr_q), .q(adr_out));

    stage_sel #(.W(MASK_W)) u_msk_sel (
        .sel_reg(reg_mode), .d_thru(ctl_dqm), .d_reg(msk_q), .q(arr_dqm));

    assign {arr_cs_n, arr_ras_n, arr_cas_n, arr_we_n, arr_cke} = ctl_out;
    assign {arr_bank, arr_addr} = adr_out;

    // Decode what the array will act on, from the array-side lines.
    always_comb begin
        arr_cmd = cmd_code(~&arr_cs_n, arr_ras_n, arr_cas_n, arr_we_n);
    end

    cl_calc #(.CL_W(CL_W)) u_cl (
        .reg_mode(reg_mode), .dev_cl(dev_cl), .eff_cl(eff_cl));

endmodule

// File: rtl/cmd_redrive_chk.sv
// Property checker for the command re-drive stage, attached through bind.
// Assumes reg_mode is static between resets.
module cmd_redrive_chk #(
    parameter int NUM_CS = 2,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int MASK_W = 8,
    parameter int CL_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_mode,
    input logic [CL_W-1:0]   dev_cl,
    input logic [NUM_CS-1:0] ctl_cs_n,
    input logic              ctl_ras_n,
    input logic              ctl_cas_n,
    input logic              ctl_we_n,
    input logic              ctl_cke,
    input logic [BANK_W-1:0] ctl_bank,
    input logic [ADDR_W-1:0] ctl_addr,
    input logic [MASK_W-1:0] ctl_dqm,
    input logic [NUM_CS-1:0] arr_cs_n,
    input logic              arr_ras_n,
    input logic              arr_cas_n,
    input logic              arr_we_n,
    input logic              arr_cke,
    input logic [BANK_W-1:0] arr_bank,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [MASK_W-1:0] arr_dqm,
    input logic [2:0]        arr_cmd,
    input logic [CL_W:0]     eff_cl
);
    AST_REG_CTL_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && $past(reg_mode) && $past(rst_n)) |->
        ({arr_cs_n, arr_ras_n, arr_cas_n, arr_we_n, arr_cke} ==
         $past({ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_cke}))); // R1

    AST_REG_ADR_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && $past(reg_mode) && $past(rst_n)) |->
        ({arr_bank, arr_addr} == $past({ctl_bank, ctl_addr}))); // R1

    AST_REG_MASK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && $past(reg_mode) && $past(rst_n)) |->
        (arr_dqm == $past(ctl_dqm))); // R8

    AST_BUF_PASS: assert property (@(posedge clk)
        !reg_mode |-> ({arr_cs_n, arr_ras_n, arr_cas_n, arr_we_n, arr_cke, arr_bank,
                        arr_addr, arr_dqm} ==
                       {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_cke, ctl_bank,
                        ctl_addr, ctl_dqm})); // R3

    AST_RESET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode && $past(reg_mode) && !$past(rst_n)) |->
        (&arr_cs_n && arr_ras_n && arr_cas_n && arr_we_n && !arr_cke &&
         &arr_dqm && arr_addr == '0 && arr_bank == '0)); // R4

    AST_DESELECT_NOP: assert property (@(posedge clk)
        &arr_cs_n |-> arr_cmd == 3'b111); // R7

    AST_SELECT_CMD: assert property (@(posedge clk)
        !(&arr_cs_n) |-> arr_cmd == {arr_ras_n, arr_cas_n, arr_we_n}); // R7

    AST_CL_REG: assert property (@(posedge clk)
        reg_mode |-> (eff_cl > {1'b0, dev_cl})); // R6

    AST_CL_BUF: assert property (@(posedge clk)
        !reg_mode |-> (eff_cl == {1'b0, dev_cl})); // R6
endmodule

bind cmd_redrive_stage cmd_redrive_chk #(
    .NUM_CS(NUM_CS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W), .CL_W(CL_W)
) u_chk (.*);

// File: tb/cmd_redrive_stage_test.sv
module cmd_redrive_stage_test;
    localparam int NUM_CS = 2;
    localparam int BANK_W = 2;
    localparam int ADDR_W = 12;
    localparam int MASK_W = 8;
    localparam int CL_W   = 3;
    localparam int TOT    = NUM_CS + 4 + BANK_W + ADDR_W + MASK_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_mode = 1'b1;
    logic [CL_W-1:0] dev_cl = '0;
    logic [TOT-1:0] stim = '0;
    logic [TOT-1:0] outv;

    logic [NUM_CS-1:0] arr_cs_n;
    logic arr_ras_n, arr_cas_n, arr_we_n, arr_cke;
    logic [BANK_W-1:0] arr_bank;
    logic [ADDR_W-1:0] arr_addr;
    logic [MASK_W-1:0] arr_dqm;
    logic [2:0] arr_cmd;
    logic [CL_W:0] eff_cl;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cmd_redrive_stage #(.NUM_CS(NUM_CS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
                        .MASK_W(MASK_W), .CL_W(CL_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode), .dev_cl(dev_cl),
        .ctl_cs_n(stim[TOT-1 -: NUM_CS]), .ctl_ras_n(stim[TOT-NUM_CS-1]),
        .ctl_cas_n(stim[TOT-NUM_CS-2]), .ctl_we_n(stim[TOT-NUM_CS-3]),
        .ctl_cke(stim[TOT-NUM_CS-4]), .ctl_bank(stim[ADDR_W+MASK_W +: BANK_W]),
        .ctl_addr(stim[MASK_W +: ADDR_W]), .ctl_dqm(stim[MASK_W-1:0]),
        .arr_cs_n(arr_cs_n), .arr_ras_n(arr_ras_n), .arr_cas_n(arr_cas_n),
        .arr_we_n(arr_we_n), .arr_cke(arr_cke), .arr_bank(arr_bank),
        .arr_addr(arr_addr), .arr_dqm(arr_dqm), .arr_cmd(arr_cmd), .eff_cl(eff_cl));

    assign outv = {arr_cs_n, arr_ras_n, arr_cas_n, arr_we_n, arr_cke, arr_bank, arr_addr, arr_dqm};

    function automatic logic [TOT-1:0] pat(input int i);
        logic [31:0] h;
        h = (i * 32'h9E3779B1) ^ (i << 7) ^ 32'h5A5A_1234;
        return h[TOT-1:0];
    endfunction

    function automatic logic [2:0] exp_cmd(input logic [TOT-1:0] v);
        if (&v[TOT-1 -: NUM_CS]) return 3'b111;
        return v[TOT-NUM_CS-1 -: 3];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic [TOT-1:0] exp);
        chk(req, {{(32-TOT){1'b0}}, outv}, {{(32-TOT){1'b0}}, exp});
        chk("R7 command decode", {29'd0, arr_cmd}, {29'd0, exp_cmd(exp)});
    endtask

    localparam logic [TOT-1:0] RST_EXP = {{NUM_CS{1'b1}}, 3'b111, 1'b0,
                                          {(BANK_W+ADDR_W){1'b0}}, {MASK_W{1'b1}}};

    initial begin
        // R4: registered-mode reset values, with busy inputs present
        reg_mode = 1'b1;
        rst_n = 1'b0;
        stim = pat(3) & ~{{NUM_CS{1'b1}}, {(TOT-NUM_CS){1'b0}}};
        @(negedge clk);
        @(negedge clk);
        chk_vec("R4 reset values", RST_EXP);
        // R6: latency sweep in registered mode
        for (int c = 0; c < (1 << CL_W); c++) begin
            dev_cl = CL_W'(c);
            #1 chk("R6 eff_cl registered", {28'd0, eff_cl}, 32'(c + 1));
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1 R2 R8: registered sweep
        for (int i = 0; i < 400; i++) begin
            logic [TOT-1:0] v;
            v = pat(i);
            stim = v;
            @(posedge clk);
            #3 stim = ~v;
            #1 chk_vec("R2 held while inputs move", v);
            @(negedge clk);
            chk_vec("R1 R8 one-clock delay", v);
        end
        // R7: every chip-select combination with every strobe value
        for (int s = 0; s < (1 << (NUM_CS + 3)); s++) begin
            logic [TOT-1:0] v;
            v = pat(s + 900);
            v[TOT-1 -: NUM_CS+3] = (NUM_CS+3)'(s);
            stim = v;
            @(negedge clk);
            chk_vec("R7 decode registered", v);
        end
        // R8: walking single mask bit, registered
        for (int b = 0; b < MASK_W; b++) begin
            logic [TOT-1:0] v;
            v = pat(b + 50);
            v[MASK_W-1:0] = MASK_W'(1) << b;
            stim = v;
            @(negedge clk);
            chk("R8 mask bit registered", {24'd0, arr_dqm}, {24'd0, v[MASK_W-1:0]});
        end
        // R3 R5: buffered mode, reset held low, outputs follow immediately
        rst_n = 1'b0;
        reg_mode = 1'b0;
        for (int i = 0; i < 200; i++) begin
            logic [TOT-1:0] v;
            v = pat(i + 2000);
            @(negedge clk);
            stim = v;
            #1 chk_vec("R5 buffered during reset", v);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            logic [TOT-1:0] v;
            v = pat(i + 5000);
            stim = v;
            #1 chk_vec("R3 same-cycle pass", v);
            @(posedge clk);
            #2 chk_vec("R3 pass after edge", v);
            v = ~v;
            stim = v;
            #1 chk_vec("R3 mid-cycle change", v);
            @(negedge clk);
        end
        for (int b = 0; b < MASK_W; b++) begin
            stim[MASK_W-1:0] = ~(MASK_W'(1) << b);
            #1 chk("R8 mask bit buffered", {24'd0, arr_dqm}, {24'd0, ~(8'(1) << b)});
        end
        for (int c = 0; c < (1 << CL_W); c++) begin
            dev_cl = CL_W'(c);
            #1 chk("R6 eff_cl buffered", {28'd0, eff_cl}, 32'(c));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule